// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small 32-bit core from normal execution into an exception or interrupt handler. Four kinds of event can be pending: trap/break, non-maskable interrupt (NMI), bus fault and external interrupt. When it is idle and at least one request is present, the block picks one event by fixed priority. In that same cycle it captures the program counter, the delay-slot flag, the status word, the stack pointers and the exception base address.

From the captured state the block works out the context update. This covers the return address and the special register that receives it, the exception-status word, the new status word, and a stack swap when the core was in user mode. It then reads one handler address from the vector table over a valid/ready read port. The word returned becomes the new PC, and every result is presented during a single done cycle. When the version input is below a threshold, a reduced legacy path is used instead.

Top module: `exc_entry_seq`

## Requirements
- R1: Requests are sampled only while idle, by the priority NMI > bus fault > trap > interrupt. `evt_o` reports the accepted class from the next cycle on, encoded 1 trap, 2 NMI, 3 bus fault, 4 interrupt, 0 none.
- R2: On the normal path the vector and return register depend on the event. A trap uses `trap_vec_i` and returns through the exception register (`ret_sel_o`=0). An NMI uses vector 0, clears status bit 9 and returns through the NMI register (`ret_sel_o`=1). A bus fault uses `fault_vec_i` and `ret_sel_o`=0. An interrupt uses `irq_vec_i` and `ret_sel_o`=0.
- R3: On the normal path `exs_we_o` pulses with done. `exs_o` holds the low 8 vector bits in bits 15:8, and every other bit is zero.
- R4: On the normal path `ret_addr_o` equals the captured PC minus the delay-slot flag (0 or 1), and `dslot_clr_o` pulses with done.
- R5: When status bit 8 (user) is set, `stack_swap_o` pulses with done, `usp_o` holds the old SP and `sp_o` holds the kernel SP. Otherwise `sp_o` holds the old SP and no swap is flagged.
- R6: On the normal path the new status word keeps bits 31:30, moves the old bits 19:0 (after any NMI clear) to bits 29:10, and zeroes bits 9:0.
- R7: Two cycles after acceptance `rd_req_valid_o` rises with address = base + vector*4. The address holds until `rd_req_ready_i`. After the handshake, the cycle following the one in which `rd_rsp_valid_i` is sampled shows `done_o` high for exactly one cycle, with `new_pc_o` equal to the returned data.
- R8: When `ver_i` < 32 the legacy path runs. Trap and NMI return through the break register (`ret_sel_o`=2) and an interrupt through the exception register. The return address is the PC unchanged. Status bit 10 is set, bit 9 is cleared for an NMI, and there is no shift, no `exs_we_o` and no `dslot_clr_o`.
- R9: A legacy-path bus fault raises `unsupported_o` in the cycle after acceptance. No read is issued, no done occurs, and the block is idle again one cycle later.
- R10: `recursive_fault_o` is high while a bus-fault entry is in progress and `bfault_req_i` is asserted again. It stays low during other entries.
- R11: `busy_o` is high from the cycle after acceptance through the done cycle. The cycle after done shows `busy_o` low and `evt_o` = 0.
- R12: After reset the block is idle: `busy_o`, `done_o`, `rd_req_valid_o` and `new_pc_o` are zero and `evt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_req_i | input | 1 | NMI pending |
| bfault_req_i | input | 1 | Bus fault pending |
| trap_req_i | input | 1 | Trap/break pending |
| irq_req_i | input | 1 | External interrupt pending |
| trap_vec_i | input | 8 | Trap vector |
| fault_vec_i | input | 8 | Bus-fault vector from translation |
| irq_vec_i | input | 8 | Interrupt-controller vector |
| ver_i | input | 8 | Core version value |
| pc_i | input | 32 | Current PC |
| dslot_i | input | 1 | Delay-slot flag |
| ccs_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| ebp_i | input | 32 | Vector table base |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | 32 | Read address |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | 32 | Read data |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Entry complete, one cycle |
| evt_o | output | 3 | Event class in progress |
| ret_addr_o | output | 32 | Return address to save |
| ret_sel_o | output | 2 | Return register: 0 exception, 1 NMI, 2 break |
| exs_o | output | 32 | Exception-status value |
| exs_we_o | output | 1 | Exception-status write |
| ccs_o | output | 32 | New status word |
| sp_o | output | 32 | New stack pointer |
| usp_o | output | 32 | Saved user stack pointer |
| stack_swap_o | output | 1 | Stack swap performed |
| dslot_clr_o | output | 1 | Clear delay-slot flag |
| new_pc_o | output | 32 | Handler address |
| unsupported_o | output | 1 | Legacy bus fault rejected |
| recursive_fault_o | output | 1 | Bus fault during bus-fault entry |

## Verification
Acceptance happens at the edge after the request is driven. `busy_o` and `evt_o` are therefore due one cycle later, and `unsupported_o` or `recursive_fault_o` are read in that same cycle. The read request is due two cycles after acceptance. All context results and `new_pc_o` are due in the cycle after the response is sampled. The bench drives every input on the falling edge and reads each output on the falling edge of the cycle where it is due. It varies request-ready and response delays at random, so every check is tied to the handshake rather than to a fixed latency.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    EVT_NONE   = 3'd0,
    EVT_TRAP   = 3'd1,
    EVT_NMI    = 3'd2,
    EVT_BFAULT = 3'd3,
    EVT_IRQ    = 3'd4
  } evt_e;

  typedef enum logic [1:0] {
    RET_ERP = 2'd0,
    RET_NRP = 2'd1,
    RET_BRP = 2'd2
  } ret_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAVE,
    ST_FETCH,
    ST_DONE
  } st_e;
endpackage

// File: rtl/exc_evt_arb.sv
module exc_evt_arb
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             nmi_i,
  input  logic             bfault_i,
  input  logic             trap_i,
  input  logic             irq_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic [VEC_W-1:0] fault_vec_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  output evt_e             evt_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    evt_o = EVT_NONE;
    vec_o = '0;
    if (nmi_i) begin
      evt_o = EVT_NMI;
    end else if (bfault_i) begin
      evt_o = EVT_BFAULT;
      vec_o = fault_vec_i;
    end else if (trap_i) begin
      evt_o = EVT_TRAP;
      vec_o = trap_vec_i;
    end else if (irq_i) begin
      evt_o = EVT_IRQ;
      vec_o = irq_vec_i;
    end
  end
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
  import exc_entry_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int U_BIT   = 8,
  parameter int M_BIT   = 9,
  parameter int F_BIT   = 10,
  parameter int SHIFT   = 10,
  parameter int KEEP_HI = 2
) (
  input  evt_e             evt_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             legacy_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             dslot_i,
  input  logic [XLEN-1:0]  ccs_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  ksp_i,
  output logic [XLEN-1:0]  ret_addr_o,
  output ret_sel_e         ret_sel_o,
  output logic [XLEN-1:0]  exs_o,
  output logic             exs_en_o,
  output logic [XLEN-1:0]  ccs_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  usp_o,
  output logic             swap_o,
  output logic             dclr_o
);
  localparam logic [XLEN-1:0] HI_MASK = ~({XLEN{1'b1}} >> KEEP_HI);
  localparam logic [XLEN-1:0] LO_MASK = {XLEN{1'b1}} >> (XLEN - SHIFT);
  localparam int IDX_POS = 8;

  logic [XLEN-1:0] ccs_m;
  logic [7:0]      idx;

  assign idx    = 8'(vec_i);
  assign swap_o = ccs_i[U_BIT];
  assign sp_o   = swap_o ? ksp_i : sp_i;
  assign usp_o  = sp_i;

  always_comb begin
    ccs_m = ccs_i;
    if (evt_i == EVT_NMI) ccs_m[M_BIT] = 1'b0;
  end

  generate
    if (SHIFT > 0) begin : g_shift
      always_comb begin
        if (legacy_i) begin
          ccs_o = ccs_m | (XLEN'(1) << F_BIT);
        end else begin
          ccs_o = (ccs_m & HI_MASK) | ((ccs_m << SHIFT) & ~HI_MASK & ~LO_MASK);
        end
      end
    end else begin : g_noshift
      always_comb begin
        ccs_o = legacy_i ? (ccs_m | (XLEN'(1) << F_BIT)) : ccs_m;
      end
    end
  endgenerate

  always_comb begin
    exs_en_o   = !legacy_i;
    dclr_o     = !legacy_i;
    exs_o      = legacy_i ? '0 : (XLEN'(idx) << IDX_POS);
    ret_addr_o = legacy_i ? pc_i : (pc_i - XLEN'(dslot_i));
    ret_sel_o  = RET_ERP;
    if (legacy_i) begin
      if (evt_i == EVT_TRAP || evt_i == EVT_NMI) ret_sel_o = RET_BRP;
    end else if (evt_i == EVT_NMI) begin
      ret_sel_o = RET_NRP;
    end
  end
endmodule

// File: rtl/exc_fetch_fsm.sv
module exc_fetch_fsm
  import exc_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output st_e  state_o,
  output logic req_valid_o,
  output logic rsp_take_o,
  output logic done_o
);
  st_e  state_q;
  logic issued_q;

  assign state_o     = state_q;
  assign req_valid_o = (state_q == ST_FETCH) && !issued_q;
  assign rsp_take_o  = (state_q == ST_FETCH) && issued_q && rsp_valid_i;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_SAVE;
        ST_SAVE:  state_q <= abort_i ? ST_IDLE : ST_FETCH;
        ST_FETCH: begin
          if (req_valid_o && req_ready_i) issued_q <= 1'b1;
          if (rsp_take_o) begin
            issued_q <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int VER_W      = 8,
  parameter int LEGACY_VER = 32,
  parameter int U_BIT      = 8,
  parameter int M_BIT      = 9,
  parameter int F_BIT      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_req_i,
  input  logic             bfault_req_i,
  input  logic             trap_req_i,
  input  logic             irq_req_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic [VEC_W-1:0] fault_vec_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic [VER_W-1:0] ver_i,
  input  logic [31:0]      pc_i,
  input  logic             dslot_i,
  input  logic [31:0]      ccs_i,
  input  logic [31:0]      sp_i,
  input  logic [31:0]      ksp_i,
  input  logic [31:0]      ebp_i,
  output logic             rd_req_valid_o,
  input  logic             rd_req_ready_i,
  output logic [31:0]      rd_addr_o,
  input  logic             rd_rsp_valid_i,
  input  logic [31:0]      rd_rsp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       evt_o,
  output logic [31:0]      ret_addr_o,
  output logic [1:0]       ret_sel_o,
  output logic [31:0]      exs_o,
  output logic             exs_we_o,
  output logic [31:0]      ccs_o,
  output logic [31:0]      sp_o,
  output logic [31:0]      usp_o,
  output logic             stack_swap_o,
  output logic             dslot_clr_o,
  output logic [31:0]      new_pc_o,
  output logic             unsupported_o,
  output logic             recursive_fault_o
);
  evt_e             arb_evt, evt_q;
  logic [VEC_W-1:0] arb_vec, vec_q;
  logic             legacy_q, dslot_q;
  logic [XLEN-1:0]  pc_q, ccs_q, sp_q, ksp_q, ebp_q;
  st_e              state;
  logic             accept, abort, commit, rsp_take;

  logic [XLEN-1:0]  c_ret, c_exs, c_ccs, c_sp, c_usp;
  ret_sel_e         c_sel;
  logic             c_exs_en, c_swap, c_dclr;

  logic [XLEN-1:0]  ret_q, exs_q, ccs_oq, sp_oq, usp_q, npc_q;
  ret_sel_e         sel_q;
  logic             exs_en_q, swap_q, dclr_q;

  exc_evt_arb #(.VEC_W(VEC_W)) u_arb (
    .nmi_i      (nmi_req_i),
    .bfault_i   (bfault_req_i),
    .trap_i     (trap_req_i),
    .irq_i      (irq_req_i),
    .trap_vec_i (trap_vec_i),
    .fault_vec_i(fault_vec_i),
    .irq_vec_i  (irq_vec_i),
    .evt_o      (arb_evt),
    .vec_o      (arb_vec)
  );

  assign accept = (state == ST_IDLE) && (arb_evt != EVT_NONE);
  assign abort  = (state == ST_SAVE) && legacy_q && (evt_q == EVT_BFAULT);
  assign commit = (state == ST_SAVE) && !abort;

  exc_fetch_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .abort_i    (abort),
    .req_ready_i(rd_req_ready_i),
    .rsp_valid_i(rd_rsp_valid_i),
    .state_o    (state),
    .req_valid_o(rd_req_valid_o),
    .rsp_take_o (rsp_take),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= EVT_NONE;
      vec_q    <= '0;
      legacy_q <= 1'b0;
      dslot_q  <= 1'b0;
      pc_q     <= '0;
      ccs_q    <= '0;
      sp_q     <= '0;
      ksp_q    <= '0;
      ebp_q    <= '0;
    end else if (accept) begin
      evt_q    <= arb_evt;
      vec_q    <= arb_vec;
      legacy_q <= (ver_i < VER_W'(LEGACY_VER));
      dslot_q  <= dslot_i;
      pc_q     <= pc_i;
      ccs_q    <= ccs_i;
      sp_q     <= sp_i;
      ksp_q    <= ksp_i;
      ebp_q    <= ebp_i;
    end else if (done_o || abort) begin
      evt_q    <= EVT_NONE;
    end
  end

  exc_ctx_calc #(
    .VEC_W(VEC_W), .U_BIT(U_BIT), .M_BIT(M_BIT), .F_BIT(F_BIT),
    .SHIFT(10), .KEEP_HI(2)
  ) u_ctx (
    .evt_i     (evt_q),
    .vec_i     (vec_q),
    .legacy_i  (legacy_q),
    .pc_i      (pc_q),
    .dslot_i   (dslot_q),
    .ccs_i     (ccs_q),
    .sp_i      (sp_q),
    .ksp_i     (ksp_q),
    .ret_addr_o(c_ret),
    .ret_sel_o (c_sel),
    .exs_o     (c_exs),
    .exs_en_o  (c_exs_en),
    .ccs_o     (c_ccs),
    .sp_o      (c_sp),
    .usp_o     (c_usp),
    .swap_o    (c_swap),
    .dclr_o    (c_dclr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q    <= '0;
      sel_q    <= RET_ERP;
      exs_q    <= '0;
      exs_en_q <= 1'b0;
      ccs_oq   <= '0;
      sp_oq    <= '0;
      usp_q    <= '0;
      swap_q   <= 1'b0;
      dclr_q   <= 1'b0;
    end else if (commit) begin
      ret_q    <= c_ret;
      sel_q    <= c_sel;
      exs_q    <= c_exs;
      exs_en_q <= c_exs_en;
      ccs_oq   <= c_ccs;
      sp_oq    <= c_sp;
      usp_q    <= c_usp;
      swap_q   <= c_swap;
      dclr_q   <= c_dclr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       npc_q <= '0;
    else if (rsp_take) npc_q <= rd_rsp_data_i;
  end

  assign rd_addr_o         = ebp_q + (XLEN'(vec_q) << 2);
  assign busy_o            = (state != ST_IDLE);
  assign evt_o             = evt_q;
  assign ret_addr_o        = ret_q;
  assign ret_sel_o         = sel_q;
  assign exs_o             = exs_q;
  assign exs_we_o          = done_o && exs_en_q;
  assign ccs_o             = ccs_oq;
  assign sp_o              = sp_oq;
  assign usp_o             = usp_q;
  assign stack_swap_o      = done_o && swap_q;
  assign dslot_clr_o       = done_o && dclr_q;
  assign new_pc_o          = npc_q;
  assign unsupported_o     = abort;
  assign recursive_fault_o = (evt_q == EVT_BFAULT) && bfault_req_i;

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> $stable(rd_addr_o));
  p_evt_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (evt_o == 3'd0) && !busy_o);
  p_busy_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_exs_fmt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exs_we_o |-> (exs_o[7:0] == 8'd0) && (exs_o[31:16] == 16'd0));
  p_user_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && exs_we_o |-> !ccs_o[U_BIT] && (ccs_o[9:0] == 10'd0));
  p_unsup_nofetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |=> !rd_req_valid_o && !busy_o);
  p_single_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !unsupported_o |=> busy_o && $stable(evt_o));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi = 0, bf = 0, trp = 0, irq = 0;
  logic [7:0]  tvec = 0, fvec = 0, ivec = 0, ver = 0;
  logic [31:0] pc = 0, ccs = 0, sp = 0, ksp = 0, ebp = 0;
  logic        dslot = 0;
  logic        rq_valid, rq_ready = 0, rsp_valid = 0;
  logic [31:0] rd_addr, rsp_data = 0;
  logic        busy, done, exs_we, swap, dclr, unsup, recur;
  logic [2:0]  evt;
  logic [1:0]  rsel;
  logic [31:0] raddr, exs, ccs_n, sp_n, usp, npc;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .nmi_req_i(nmi), .bfault_req_i(bf), .trap_req_i(trp), .irq_req_i(irq),
    .trap_vec_i(tvec), .fault_vec_i(fvec), .irq_vec_i(ivec), .ver_i(ver),
    .pc_i(pc), .dslot_i(dslot), .ccs_i(ccs), .sp_i(sp), .ksp_i(ksp), .ebp_i(ebp),
    .rd_req_valid_o(rq_valid), .rd_req_ready_i(rq_ready), .rd_addr_o(rd_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
    .busy_o(busy), .done_o(done), .evt_o(evt), .ret_addr_o(raddr), .ret_sel_o(rsel),
    .exs_o(exs), .exs_we_o(exs_we), .ccs_o(ccs_n), .sp_o(sp_n), .usp_o(usp),
    .stack_swap_o(swap), .dslot_clr_o(dclr), .new_pc_o(npc),
    .unsupported_o(unsup), .recursive_fault_o(recur)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  // Expected class: 1 trap, 2 NMI, 3 bus fault, 4 interrupt
  function automatic int pick(input bit n, input bit b, input bit t, input bit i);
    if (n) return 2;
    if (b) return 3;
    if (t) return 1;
    if (i) return 4;
    return 0;
  endfunction

  task automatic run_evt(input bit n, input bit b, input bit t, input bit i,
                         input bit poke_bf);
    int cls;
    bit leg, user;
    logic [7:0]  v;
    logic [31:0] m, e_ccs, e_ret;
    logic [1:0]  e_sel;
    logic [31:0] a;
    bit hs;
    int k, d;
    cls  = pick(n, b, t, i);
    leg  = (ver < 8'd32);
    user = ccs[8];
    v    = (cls == 1) ? tvec : (cls == 3) ? fvec : (cls == 4) ? ivec : 8'd0;
    m    = ccs;
    if (cls == 2) m[9] = 1'b0;
    if (leg) begin
      e_ccs = m | 32'h0000_0400;
      e_ret = pc;
      e_sel = (cls == 1 || cls == 2) ? 2'd2 : 2'd0;
    end else begin
      e_ccs = (m & 32'hC000_0000) | ((m << 10) & 32'h3FFF_FC00);
      e_ret = pc - {31'd0, dslot};
      e_sel = (cls == 2) ? 2'd1 : 2'd0;
    end
    nmi = n; bf = b; trp = t; irq = i;
    @(negedge clk);
    nmi = 0; bf = 0; trp = 0; irq = 0;
    chk("R1 evt class", {29'd0, evt}, cls);
    chk("R11 busy after accept", {31'd0, busy}, 1);
    chk("R7 no early request", {31'd0, rq_valid}, 0);
    if (poke_bf) begin
      bf = 1; #1;
      chk("R10 recursive fault", {31'd0, recur}, (cls == 3) ? 1 : 0);
      bf = 0;
    end
    if (leg && cls == 3) begin
      chk("R9 unsupported", {31'd0, unsup}, 1);
      @(negedge clk);
      chk("R9 idle after reject", {31'd0, busy}, 0);
      chk("R9 no fetch", {31'd0, rq_valid}, 0);
      chk("R9 no done", {31'd0, done}, 0);
      return;
    end
    chk("R9 no unsupported", {31'd0, unsup}, 0);
    @(negedge clk);
    chk("R7 request valid", {31'd0, rq_valid}, 1);
    chk("R7 vector address", rd_addr, ebp + {22'd0, v, 2'b00});
    a = rd_addr;
    k = 0;
    do begin
      rq_ready = ($urandom % 2 == 0) || (k >= 4);
      hs = rq_valid && rq_ready;
      if (!hs) chk("R7 address held", rd_addr, a);
      @(negedge clk);
      k++;
    end while (!hs);
    rq_ready = 0;
    chk("R7 request drops", {31'd0, rq_valid}, 0);
    d = $urandom % 3;
    for (int j = 0; j < d; j++) begin
      chk("R7 no done before data", {31'd0, done}, 0);
      @(negedge clk);
    end
    rsp_valid = 1;
    rsp_data  = mem_word(a);
    @(negedge clk);
    rsp_valid = 0;
    chk("R7 done", {31'd0, done}, 1);
    chk("R7 new pc", npc, mem_word(a));
    chk("R11 busy at done", {31'd0, busy}, 1);
    chk(leg ? "R8 return select" : "R2 return select", {30'd0, rsel}, {30'd0, e_sel});
    chk(leg ? "R8 return addr" : "R4 return addr", raddr, e_ret);
    chk(leg ? "R8 status" : "R6 status", ccs_n, e_ccs);
    chk(leg ? "R8 no exs" : "R3 exs write", {31'd0, exs_we}, leg ? 0 : 1);
    if (!leg) chk("R3 exs value", exs, {16'd0, v, 8'd0});
    chk(leg ? "R8 no dslot clr" : "R4 dslot clr", {31'd0, dclr}, leg ? 0 : 1);
    chk("R5 swap flag", {31'd0, swap}, {31'd0, user});
    chk("R5 sp", sp_n, user ? ksp : sp);
    if (user) chk("R5 usp", usp, sp);
    @(negedge clk);
    chk("R7 done one cycle", {31'd0, done}, 0);
    chk("R11 evt cleared", {29'd0, evt}, 0);
    chk("R11 idle", {31'd0, busy}, 0);
  endtask

  task automatic set_ctx(input logic [7:0] vr, input logic [31:0] c, input bit ds);
    ver = vr; ccs = c; dslot = ds;
    pc  = $urandom; sp = $urandom; ksp = $urandom;
    ebp = $urandom & 32'hFFFF_F000;
    tvec = $urandom; fvec = $urandom; ivec = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #5;
    chk("R12 busy reset", {31'd0, busy}, 0);
    chk("R12 done reset", {31'd0, done}, 0);
    chk("R12 req reset", {31'd0, rq_valid}, 0);
    chk("R12 evt reset", {29'd0, evt}, 0);
    chk("R12 pc reset", npc, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // directed: each class, normal path, user and kernel mode, both dslot values
    set_ctx(8'd40, 32'hABCD_E3FF, 1'b1); run_evt(0, 0, 1, 0, 1);
    set_ctx(8'd40, 32'h0000_0300, 1'b0); run_evt(1, 0, 0, 0, 1);
    set_ctx(8'd40, 32'hFFFF_FFFF, 1'b1); run_evt(0, 1, 0, 0, 1);
    set_ctx(8'd40, 32'h0000_0000, 1'b0); run_evt(0, 0, 0, 1, 0);
    // priority combinations
    set_ctx(8'd40, 32'h8000_0100, 1'b0); run_evt(1, 1, 1, 1, 0);
    set_ctx(8'd40, 32'h4000_0000, 1'b1); run_evt(0, 1, 1, 1, 1);
    set_ctx(8'd40, 32'h0000_0200, 1'b0); run_evt(0, 0, 1, 1, 0);
    // legacy path
    set_ctx(8'd10, 32'h0000_0300, 1'b1); run_evt(1, 0, 0, 0, 0);
    set_ctx(8'd31, 32'h0000_0000, 1'b1); run_evt(0, 0, 1, 0, 0);
    set_ctx(8'd0,  32'h0000_0100, 1'b0); run_evt(0, 0, 0, 1, 0);
    set_ctx(8'd31, 32'h0000_0000, 1'b0); run_evt(0, 1, 0, 0, 0);
    set_ctx(8'd32, 32'h0000_0100, 1'b1); run_evt(0, 0, 1, 0, 0);

    for (int it = 0; it < 80; it++) begin
      bit n, b, t, i;
      logic [3:0] r;
      r = 4'($urandom);
      if (r == 0) r = 4'd8;
      {n, b, t, i} = r;
      set_ctx(8'($urandom % 64), $urandom, 1'($urandom));
      run_evt(n, b, t, i, 1'($urandom));
      repeat ($urandom % 2) @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule